// File: doc/BRIEF.md
# Edge-Clocked Circulating Pattern Shifter

This block plays a short bit pattern out of one serial pin, one bit for each edge of an external trigger. The trigger has no fixed relation to the system clock. It passes through a synchroniser and an edge detector, and the pattern then steps one place to the left. The bit that leaves the top of the active length drives the output pin and re-enters at bit 0, so the pattern repeats for as long as edges keep arriving.

A host can change the pattern and its length, from 4 to 16 bits, while the output keeps running. A write goes into a one-word holding buffer, and a small state machine tracks whether that buffer is empty or holds a word. The held word replaces the running pattern only at a frame boundary, which is the shift that puts out the last bit of the current frame. The running frame is never cut short. The state machine has two states. In `BUF_EMPTY` it stays put until a write arrives (transition *fill*, to `BUF_HELD`). In `BUF_HELD` a further write replaces the held word (transition *overwrite*), and a frame boundary with no write in that cycle hands the word to the shifter (transition *drain*, back to `BUF_EMPTY`). The buffer-empty flag is high in `BUF_EMPTY`, and the host reloads the buffer whenever it sees that flag. Back-to-back patterns then follow each other with no gap.

From a change on the trigger to the new output value there are three system clock cycles: two synchroniser flops, then the register that does the shift. At 40 MHz that is 75 ns, well below a 0.5 µs budget.

Top module: `pshift_top`

## Requirements
- R1: After reset `ser_out` is 0, `buf_empty` is 1, and the running pattern is 11000010 with length 8. The first active edge puts out 1, followed by 1,0,0,0,0,1,0, and the frame then repeats.
- R2: Each active edge shifts the pattern one place left within the active length L. The bit leaving position L-1 drives `ser_out` and re-enters at bit 0, so with no held word the same L bits repeat.
- R3: A written length below 4 is taken as 4, and a length above 16 is taken as 16. The running pattern is the low L bits of the written word, played highest bit first.
- R4: With `edge_fall` = 0 only rising edges of `trig_in` shift, and with `edge_fall` = 1 only falling edges shift. An edge of the other direction leaves `ser_out` unchanged.
- R5: `ser_out` takes its new value on the third rising clock edge after `trig_in` changes, and not earlier.
- R6: A write (`wr_en` high for one cycle) stores `wr_word` and `wr_len` in the holding buffer, and `buf_empty` is low from the next cycle. The frame in progress finishes with the old pattern and the old length.
- R7: At a frame boundary a held word and its length replace the running pattern and `buf_empty` returns to 1. With nothing held, the pattern recirculates and `buf_empty` stays 1.
- R8: If a write lands in the same cycle as a boundary shift, the word held before that cycle (if any) enters the shifter and the new word stays held, so `buf_empty` is 0 afterwards. If nothing was held, the pattern recirculates and the new word stays held.
- R9: A second write while a word is held replaces it, and only the latest word plays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | External trigger, asynchronous to `clk` |
| edge_fall | input | 1 | Active trigger edge: 0 rising, 1 falling |
| wr_en | input | 1 | One-cycle write strobe for the holding buffer |
| wr_word | input | MAX_LEN | New pattern; the low L bits are used |
| wr_len | input | LEN_W | New length L, clamped to 4..16 |
| buf_empty | output | 1 | High when the holding buffer can take a new word |
| ser_out | output | 1 | Serial pattern output |

## Verification
The two functions that can fall in one clock cycle are a host write and the boundary shift that drains the buffer. The bench provokes this by raising the trigger and then placing `wr_en` in the cycle where the synchronised edge reaches the shift register, which is the third clock edge. It does this once with a word already held and once with the buffer empty. Each case is judged at the ports: `buf_empty` must read 0 afterwards, the next frame must play the previously held word (or repeat the old pattern in the empty case), and the word written in the collision cycle must appear only at the boundary after that.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_HELD  = 1'b1
    } hold_state_t;

endpackage

// File: rtl/pshift_trig_sync.sv
module pshift_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic edge_fall,
    output logic shift_en
);
    // stage 0 is nearest the pin; stage SYNC_STAGES holds the previous synced value
    logic [SYNC_STAGES:0] chain_q;
    logic                 rise_seen;
    logic                 fall_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], trig_in};
        end
    end

    always_comb begin
        rise_seen = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        fall_seen = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];
        shift_en  = edge_fall ? fall_seen : rise_seen;
    end

endmodule

// File: rtl/pshift_holdbuf.sv
module pshift_holdbuf
    import pshift_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int MIN_LEN = 4,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [MAX_LEN-1:0] wr_word,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic               frame_end,
    output logic               take,
    output logic [MAX_LEN-1:0] held_word,
    output logic [LEN_W-1:0]   held_len,
    output logic               buf_empty
);
    hold_state_t      state_q;
    hold_state_t      state_d;
    logic [LEN_W-1:0] len_clamped;

    always_comb begin
        if (wr_len < LEN_W'(MIN_LEN)) begin
            len_clamped = LEN_W'(MIN_LEN);
        end else if (wr_len > LEN_W'(MAX_LEN)) begin
            len_clamped = LEN_W'(MAX_LEN);
        end else begin
            len_clamped = wr_len;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: begin
                if (wr_en) state_d = BUF_HELD;          // fill
            end
            BUF_HELD: begin
                if (wr_en)          state_d = BUF_HELD; // overwrite
                else if (frame_end) state_d = BUF_EMPTY; // drain
            end
            default: state_d = BUF_EMPTY;
        endcase
    end

    // held data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_word <= '0;
            held_len  <= LEN_W'(MIN_LEN);
        end else if (wr_en) begin
            held_word <= wr_word;
            held_len  <= len_clamped;
        end
    end

    // outputs
    always_comb begin
        take      = (state_q == BUF_HELD) && frame_end;
        buf_empty = (state_q == BUF_EMPTY);
    end

endmodule

// File: rtl/pshift_core.sv
module pshift_core #(
    parameter int               MAX_LEN    = 16,
    parameter logic [MAX_LEN-1:0] RESET_WORD = MAX_LEN'(8'hC2),
    parameter int               RESET_LEN  = 8,
    localparam int              LEN_W      = $clog2(MAX_LEN + 1),
    localparam int              IDX_W      = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               take,
    input  logic [MAX_LEN-1:0] load_word,
    input  logic [LEN_W-1:0]   load_len,
    output logic               frame_end,
    output logic [LEN_W-1:0]   cur_len,
    output logic [LEN_W-1:0]   frame_pos,
    output logic               ser_out
);
    logic [MAX_LEN-1:0] pat_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   pos_q;
    logic               out_q;
    logic [IDX_W-1:0]   top_idx;
    logic               top_bit;
    logic [MAX_LEN-1:0] rotated;
    logic [MAX_LEN-1:0] load_masked;

    always_comb begin
        top_idx = IDX_W'(len_q - 1'b1);
        top_bit = pat_q[top_idx];
        rotated = '0;
        rotated[0] = top_bit;
        for (int i = 1; i < MAX_LEN; i++) begin
            if (LEN_W'(i) < len_q) rotated[i] = pat_q[i-1];
        end
        for (int i = 0; i < MAX_LEN; i++) begin
            load_masked[i] = (LEN_W'(i) < load_len) ? load_word[i] : 1'b0;
        end
        frame_end = shift_en && (pos_q == len_q - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= RESET_WORD;
            len_q <= LEN_W'(RESET_LEN);
            pos_q <= '0;
            out_q <= 1'b0;
        end else if (shift_en) begin
            out_q <= top_bit;
            if (frame_end) begin
                pos_q <= '0;
                if (take) begin
                    pat_q <= load_masked;
                    len_q <= load_len;
                end else begin
                    pat_q <= rotated;
                end
            end else begin
                pos_q <= pos_q + 1'b1;
                pat_q <= rotated;
            end
        end
    end

    assign cur_len   = len_q;
    assign frame_pos = pos_q;
    assign ser_out   = out_q;

endmodule

// File: rtl/pshift_top.sv
module pshift_top #(
    parameter int               MAX_LEN     = 16,
    parameter int               MIN_LEN     = 4,
    parameter int               SYNC_STAGES = 2,
    parameter logic [MAX_LEN-1:0] RESET_WORD  = MAX_LEN'(8'hC2),
    parameter int               RESET_LEN   = 8,
    localparam int              LEN_W       = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_in,
    input  logic               edge_fall,
    input  logic               wr_en,
    input  logic [MAX_LEN-1:0] wr_word,
    input  logic [LEN_W-1:0]   wr_len,
    output logic               buf_empty,
    output logic               ser_out
);
    logic               shift_en;
    logic               frame_end;
    logic               take;
    logic [MAX_LEN-1:0] held_word;
    logic [LEN_W-1:0]   held_len;
    logic [LEN_W-1:0]   cur_len;
    logic [LEN_W-1:0]   frame_pos;

    pshift_trig_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .edge_fall (edge_fall),
        .shift_en  (shift_en)
    );

    pshift_holdbuf #(
        .MAX_LEN (MAX_LEN),
        .MIN_LEN (MIN_LEN)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .wr_len    (wr_len),
        .frame_end (frame_end),
        .take      (take),
        .held_word (held_word),
        .held_len  (held_len),
        .buf_empty (buf_empty)
    );

    pshift_core #(
        .MAX_LEN    (MAX_LEN),
        .RESET_WORD (RESET_WORD),
        .RESET_LEN  (RESET_LEN)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .take      (take),
        .load_word (held_word),
        .load_len  (held_len),
        .frame_end (frame_end),
        .cur_len   (cur_len),
        .frame_pos (frame_pos),
        .ser_out   (ser_out)
    );

endmodule

// File: rtl/pshift_chk.sv
module pshift_chk #(
    parameter int  MAX_LEN = 16,
    parameter int  MIN_LEN = 4,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_in,
    input logic             edge_fall,
    input logic             wr_en,
    input logic             buf_empty,
    input logic             ser_out,
    input logic             frame_end,
    input logic [LEN_W-1:0] cur_len,
    input logic [LEN_W-1:0] frame_pos
);
    // R4, R5: output moves only three clock edges after an active-direction pin change
    assert_out_follows_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_out) |->
            ($past(trig_in, 3) != $past(trig_in, 4)) &&
            ($past(trig_in, 3) == !$past(edge_fall, 3)));

    // R6: buffer turns non-empty only after a write
    assert_fill_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(wr_en));

    // R7: buffer empties only at a frame boundary with no write in that cycle
    assert_drain_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(frame_end) && !$past(wr_en));

    // R3: active length stays within its legal range
    assert_len_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len >= LEN_W'(MIN_LEN)) && (cur_len <= LEN_W'(MAX_LEN)));

    // R2: bit position inside the frame never reaches the length
    assert_pos_below_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pos < cur_len);

endmodule

bind pshift_top pshift_chk #(
    .MAX_LEN (MAX_LEN),
    .MIN_LEN (MIN_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .edge_fall (edge_fall),
    .wr_en     (wr_en),
    .buf_empty (buf_empty),
    .ser_out   (ser_out),
    .frame_end (frame_end),
    .cur_len   (cur_len),
    .frame_pos (frame_pos)
);

// File: tb/test_pshift_top.sv
module test_pshift_top;

    logic        clk       = 1'b0;
    logic        rst_n     = 1'b0;
    logic        trig_in   = 1'b0;
    logic        edge_fall = 1'b0;
    logic        wr_en     = 1'b0;
    logic [15:0] wr_word   = '0;
    logic [4:0]  wr_len    = '0;
    logic        buf_empty;
    logic        ser_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    logic [15:0] m_pat;
    int          m_len;
    int          m_cnt;
    bit          m_held;
    logic [15:0] m_hword;
    int          m_hlen;
    logic        m_out;

    // {word[36:21], len[20:16], expected frame msb-first left aligned [15:0]}
    localparam logic [36:0] VEC [5] = '{
        {16'h00A5, 5'd8,  16'hA500},
        {16'h0006, 5'd4,  16'h6000},
        {16'hF00D, 5'd16, 16'hF00D},
        {16'h1ABC, 5'd13, 16'hD5E0},
        {16'hFF35, 5'd5,  16'hA800}
    };

    pshift_top i_pshift_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .edge_fall (edge_fall),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .wr_len    (wr_len),
        .buf_empty (buf_empty),
        .ser_out   (ser_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic int clamp_len(input int l);
        if (l < 4) return 4;
        if (l > 16) return 16;
        return l;
    endfunction

    task automatic m_reset();
        m_pat = 16'h00C2; m_len = 8; m_cnt = 0; m_held = 0;
        m_hword = '0; m_hlen = 4; m_out = 1'b0;
    endtask

    task automatic m_write(input logic [15:0] w, input int l);
        m_held  = 1;
        m_hword = w;
        m_hlen  = clamp_len(l);
    endtask

    task automatic m_shift();
        logic        ob;
        logic [15:0] rot;
        logic [15:0] msk;
        ob  = m_pat[m_len-1];
        rot = '0;
        for (int i = 1; i < m_len; i++) rot[i] = m_pat[i-1];
        rot[0] = ob;
        if (m_cnt == m_len - 1) begin
            m_cnt = 0;
            if (m_held) begin
                msk    = 16'(((32'h1) << m_hlen) - 1);
                m_pat  = m_hword & msk;
                m_len  = m_hlen;
                m_held = 0;
            end else begin
                m_pat = rot;
            end
        end else begin
            m_cnt++;
            m_pat = rot;
        end
        m_out = ob;
    endtask

    task automatic drv_write(input logic [15:0] w, input int l);
        @(negedge clk);
        wr_en = 1'b1; wr_word = w; wr_len = 5'(l);
        @(negedge clk);
        wr_en = 1'b0;
        m_write(w, l);
    endtask

    // one trigger pulse; the active edge per edge_fall does the shift
    task automatic step(input string req);
        @(negedge clk); trig_in = 1'b1;
        repeat (5) @(negedge clk);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
        m_shift();
        chk(req, ser_out, m_out);
    endtask

    // rising-edge pulse with a write placed in the shift cycle
    task automatic step_wr(input logic [15:0] w, input int l);
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_word = w; wr_len = 5'(l);
        @(negedge clk);
        wr_en = 1'b0;
        m_shift();
        m_write(w, l);
        repeat (2) @(negedge clk);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 collision output", ser_out, m_out);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset ser_out", ser_out, 1'b0);
        chk("R1 reset buf_empty", buf_empty, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 latency: trig set at a negedge, shift lands on the third posedge
        trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 not before third edge", ser_out, 1'b0);
        @(negedge clk);
        chk("R5 at third edge", ser_out, 1'b1);
        m_shift();
        repeat (2) @(negedge clk);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);

        // R1, R2: reset pattern and its repetition
        for (int k = 1; k < 16; k++) begin
            step("R2 model");
            chk("R1 default pattern", ser_out, 8'hC2 >> (7 - (k % 8)));
        end
        chk("R7 recirculate keeps empty", buf_empty, 1'b1);

        // table walk: R6, R7, R3
        for (int v = 0; v < 5; v++) begin
            logic [15:0] w;
            int          l;
            logic [15:0] e;
            w = VEC[v][36:21];
            l = int'(VEC[v][20:16]);
            e = VEC[v][15:0];
            drv_write(w, l);
            chk("R6 buffer held", buf_empty, 1'b0);
            while (m_held) step("R6 old frame continues");
            chk("R7 buffer drained", buf_empty, 1'b1);
            for (int k = 0; k < 2 * l; k++) begin
                step("R2 model");
                chk("R3 table pattern", ser_out, e[15 - (k % l)]);
            end
        end

        // R4 polarity: pattern 10101, next two bits are 1 then 0
        step("R2 model");
        @(negedge clk);
        edge_fall = 1'b1;
        @(negedge clk);
        trig_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 rising ignored in falling mode", ser_out, 1'b1);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
        m_shift();
        chk("R4 falling edge shifts", ser_out, 1'b0);
        step("R4 falling mode model");
        @(negedge clk);
        edge_fall = 1'b0;

        // R3 clamp low: length 2 -> 4, word 1001
        drv_write(16'h0009, 2);
        while (m_held) step("R2 model");
        for (int k = 0; k < 8; k++) begin
            step("R2 model");
            chk("R3 clamp to 4", ser_out, 4'b1001 >> (3 - (k % 4)));
        end
        // R3 clamp high: length 20 -> 16
        drv_write(16'h8001, 20);
        while (m_held) step("R2 model");
        for (int k = 0; k < 16; k++) begin
            step("R2 model");
            chk("R3 clamp to 16", ser_out, (k == 0) || (k == 15));
        end

        // R9 overwrite
        drv_write(16'h0003, 4);
        drv_write(16'h000C, 4);
        while (m_held) step("R9 model");
        for (int k = 0; k < 4; k++) begin
            step("R9 model");
            chk("R9 latest word plays", ser_out, 4'b1100 >> (3 - k));
        end

        // R8 collision with a word held
        drv_write(16'h0005, 4);
        while (m_cnt != m_len - 1) step("R2 model");
        step_wr(16'h000E, 4);
        chk("R8 held word kept", buf_empty, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step("R8 model");
            chk("R8 previous held word plays", ser_out, 4'b0101 >> (3 - k));
        end
        while (m_held) step("R8 model");
        for (int k = 0; k < 4; k++) begin
            step("R8 model");
            chk("R8 collided word plays later", ser_out, 4'b1110 >> (3 - k));
        end

        // R8 collision with an empty buffer
        while (m_cnt != m_len - 1) step("R2 model");
        step_wr(16'h0008, 4);
        chk("R8 empty collision holds word", buf_empty, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step("R8 model");
            chk("R8 recirculates", ser_out, 4'b1110 >> (3 - k));
        end
        while (m_held) step("R8 model");
        for (int k = 0; k < 4; k++) begin
            step("R8 model");
            chk("R8 new word after", ser_out, 4'b1000 >> (3 - k));
        end

        // R1 reset mid-run
        @(negedge clk);
        drv_write(16'h00FF, 8);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears out", ser_out, 1'b0);
        chk("R1 reset clears buffer", buf_empty, 1'b1);
        rst_n = 1'b1;
        m_reset();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            step("R2 model");
            chk("R1 default after reset", ser_out, 8'hC2 >> (7 - k));
        end

        done = 1;
        finish_run();
    end

endmodule